// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block takes one free-running clock and drives three kinds of gated copies of it. The first is a set of true/complement pairs. The second is a group of single-ended outputs. The third is one single-ended output that keeps running when a stop is requested. A single asynchronous, active-low stop request halts the pairs and the group. Each gated output also has its own enable bit, which comes from a configuration register clocked in the same domain. For a pair, one enable bit controls both halves.

The stop request is brought into the domain of the gated clock by a synchronizer. The pairs and the group have separate synchronizers, and each has its own depth, so the two stop latencies can differ. Each output has a small gate controller. Its state register is clocked on the falling edge, so the gate opens or closes only while the source clock is low. A stopped true output parks low and its complement parks high. The first high pulse after a restart is always a full half period.

Each gate controller has two states. GATE_PARK holds the output parked. GATE_RUN passes the clock. There are two transitions, and both are taken on a falling edge of the source clock. PARK to RUN happens when the request to run is seen. RUN to PARK happens when that request is withdrawn. The request to run is the synchronized stop level ANDed with the output's enable bit. For the free-running output, the request is its enable bit alone.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_n is low, every true and single-ended output is low and every complement output is high.
- R2: During every low phase of clk, all true, group and free outputs are low and all complement outputs are high, whatever the inputs do.
- R3: A pulse that is passed is high for the whole high phase of clk, including the first pulse after a restart.
- R4: The pair outputs pulse at the rising edge n only if stop_n was high when sampled at rising edge n-PAIR_SYNC. Stopping and restarting have the same latency. With the default of 2, this is below 4 cycles.
- R5: The group outputs follow the same rule with GRP_SYNC, which defaults to 1. The group therefore stops one clock after stop_n is sampled low, and restarts on the next rising edge after stop_n is sampled high.
- R6: Each complement output pair_c[i] is the inverse of pair_t[i] at all times.
- R7: An enable bit of 1 lets its output run and 0 parks it. Bit i of en_pair gates both halves of pair i, bit i of en_grp gates grp_clk[i], and en_free gates free_clk. The value seen at the falling edge before rising edge n decides the pulse at edge n.
- R8: free_clk depends only on en_free. It ignores stop_n completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| en_pair | input | N_PAIR | Per-pair enable bits (1 = run) |
| en_grp | input | N_GRP | Per-output enable bits for the group |
| en_free | input | 1 | Enable for the free-running output |
| pair_t | output | N_PAIR | True halves of the gated pairs |
| pair_c | output | N_PAIR | Complement halves of the gated pairs |
| grp_clk | output | N_GRP | Gated single-ended group |
| free_clk | output | 1 | Output exempt from the stop request |

## Verification
Suppose a gate controller holds the wrong state. The pulse at the next rising edge is then missing, or it appears when it should not. This shows up within one cycle of the falling edge where the error occurred. Suppose instead that a synchronizer has the wrong depth. Every stop and every restart then shifts by one or more whole pulses, and the pulse counts after each transition of stop_n expose the shift. A gate that updates on the wrong edge produces high levels in the low phase or a truncated pulse, so outputs are sampled both early and late in each high phase and also within each low phase.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

    // Gate controller states
    typedef enum logic [0:0] {
        GATE_PARK = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    // Reset value 0 means "stopped" until the request propagates
    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gate_ctrl.sv
`timescale 1ns/1ps
module gate_ctrl
    import clk_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic clk_o,
    output logic run_o
);

    gate_state_e state, state_nx;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_PARK: if (want)  state_nx = GATE_RUN;
            GATE_RUN:  if (!want) state_nx = GATE_PARK;
        endcase
    end

    // State register on the falling edge: the gate only moves while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_PARK;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        run_o = (state == GATE_RUN);
        clk_o = clk & run_o;
    end

    assert_gate_opens_R7: assert property (@(negedge clk) disable iff (!rst_n)
        want |=> run_o);
    assert_gate_parks_R7: assert property (@(negedge clk) disable iff (!rst_n)
        !want |=> !run_o);

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter int N_PAIR    = 3,
    parameter int N_GRP     = 7,
    parameter int PAIR_SYNC = 2,
    parameter int GRP_SYNC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_n,
    input  logic [N_PAIR-1:0] en_pair,
    input  logic [N_GRP-1:0]  en_grp,
    input  logic              en_free,
    output logic [N_PAIR-1:0] pair_t,
    output logic [N_PAIR-1:0] pair_c,
    output logic [N_GRP-1:0]  grp_clk,
    output logic              free_clk
);

    logic              pair_go;
    logic              grp_go;
    logic [N_PAIR-1:0] pair_run;
    logic [N_GRP-1:0]  grp_run;
    logic              free_run;

    stop_sync #(.STAGES(PAIR_SYNC)) u_sync_pair (
        .clk(clk), .rst_n(rst_n), .async_in(stop_n), .sync_out(pair_go)
    );

    stop_sync #(.STAGES(GRP_SYNC)) u_sync_grp (
        .clk(clk), .rst_n(rst_n), .async_in(stop_n), .sync_out(grp_go)
    );

    generate
        for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
            gate_ctrl u_gate (
                .clk(clk), .rst_n(rst_n),
                .want(pair_go & en_pair[i]),
                .clk_o(pair_t[i]), .run_o(pair_run[i])
            );
        end
        for (genvar j = 0; j < N_GRP; j++) begin : g_grp
            gate_ctrl u_gate (
                .clk(clk), .rst_n(rst_n),
                .want(grp_go & en_grp[j]),
                .clk_o(grp_clk[j]), .run_o(grp_run[j])
            );
        end
    endgenerate

    // Free-running output: no stop term in its request
    gate_ctrl u_free (
        .clk(clk), .rst_n(rst_n),
        .want(en_free),
        .clk_o(free_clk), .run_o(free_run)
    );

    // Complement parks high whenever the true half parks low
    assign pair_c = ~pair_t;

    assert_pair_parks_R4: assert property (@(negedge clk) disable iff (!rst_n)
        !pair_go |=> (pair_run == '0));
    assert_grp_parks_R5: assert property (@(negedge clk) disable iff (!rst_n)
        !grp_go |=> (grp_run == '0));
    assert_free_runs_R8: assert property (@(negedge clk) disable iff (!rst_n)
        en_free |=> free_run);

endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;

    localparam int NP = 3;
    localparam int NG = 7;
    localparam int SP = 2;
    localparam int SG = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic [NP-1:0] en_pair = '1;
    logic [NG-1:0] en_grp = '1;
    logic          en_free = 1'b1;
    logic [NP-1:0] pair_t, pair_c;
    logic [NG-1:0] grp_clk;
    logic          free_clk;

    always #4 clk = ~clk;

    clk_stop_gate #(.N_PAIR(NP), .N_GRP(NG), .PAIR_SYNC(SP), .GRP_SYNC(SG)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_n(stop_n),
        .en_pair(en_pair), .en_grp(en_grp), .en_free(en_free),
        .pair_t(pair_t), .pair_c(pair_c), .grp_clk(grp_clk), .free_clk(free_clk)
    );

    typedef struct packed {
        logic [NP-1:0] t;
        logic [NG-1:0] g;
        logic          f;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   hist[0:1023];
    int   n = 0;
    bit   done = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Driver: applies one cycle of inputs and pushes the expected pulse for the next edge
    task automatic step(bit s, logic [NP-1:0] ep, logic [NG-1:0] eg, bit ef, bit late);
        exp_t e;
        bit   sp, sg;
        @(posedge clk);
        #1;
        rst_n   = 1'b1;
        en_pair = ep;
        en_grp  = eg;
        en_free = ef;
        n++;
        hist[n] = s;
        sp  = (n - SP >= 1) ? hist[n - SP] : 1'b0;
        sg  = (n - SG >= 1) ? hist[n - SG] : 1'b0;
        e.t = ep & {NP{sp}};
        e.g = eg & {NG{sg}};
        e.f = ef;
        exp_q.push_back(e);
        if (late) begin
            @(negedge clk);
            #1;
        end
        stop_n = s;
    endtask

    // Monitor: compares high phases against the queue, low phases against the park levels
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                exp_t          e;
                logic [NP-1:0] ct;
                e  = exp_q.pop_front();
                ct = ~e.t;
                #1;
                chk("R4 R7", "pair_t", pair_t, e.t);
                chk("R6", "pair_c", pair_c, ct);
                chk("R5 R7", "grp_clk", grp_clk, e.g);
                chk("R8", "free_clk", free_clk, e.f);
                #2;
                chk("R3", "pair_t late", pair_t, e.t);
                chk("R3", "grp_clk late", grp_clk, e.g);
                chk("R3", "free_clk late", free_clk, e.f);
            end
            @(negedge clk);
            #2;
            if (rst_n) begin
                chk("R2", "pair_t low", pair_t, '0);
                chk("R2", "pair_c low", pair_c, {NP{1'b1}});
                chk("R2", "grp_clk low", grp_clk, '0);
                chk("R2", "free_clk low", free_clk, '0);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R1: parked during reset, sampled in the high phase
        repeat (3) begin
            @(posedge clk);
            #2;
            chk("R1", "pair_t reset", pair_t, '0);
            chk("R1", "pair_c reset", pair_c, {NP{1'b1}});
            chk("R1", "grp_clk reset", grp_clk, '0);
            chk("R1", "free_clk reset", free_clk, '0);
        end
        repeat (6) step(1'b1, '1, '1, 1'b1, 1'b0);
        // R4 R5 R8: stop with free output still running
        repeat (6) step(1'b0, '1, '1, 1'b1, 1'b0);
        repeat (6) step(1'b1, '1, '1, 1'b1, 1'b0);
        // R7: sparse enable patterns
        repeat (4) step(1'b1, 3'b101, 7'h55, 1'b0, 1'b0);
        // single-cycle stop request
        step(1'b0, '1, '1, 1'b1, 1'b0);
        repeat (4) step(1'b1, '1, '1, 1'b1, 1'b0);
        // stop request changing in the low phase
        repeat (3) step(1'b0, '1, '1, 1'b1, 1'b1);
        repeat (4) step(1'b1, '1, '1, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            step((i % 7) > 1, NP'(i * 5), NG'(i * 37), i[0], (i % 3) == 0);
        end
        repeat (4) step(1'b1, '1, '1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        summary();
    end

endmodule